// File: doc/BRIEF.md
# SPI Flash Command Gatekeeper

This block sits behind the serial shifter of an SPI NOR flash slave. It decides how each framed transaction is handled, and it owns the 8-bit status register. The shifter presents a transaction for one cycle. A transaction carries the opcode, the number of bytes written including the opcode, the number of bytes read, and the first five bytes that follow the opcode. One cycle later the block reports a single result: ok, error or invalid-opcode. In the same cycle it presents any access to the backing store: an address, a length and one of three enables (program, read, erase-fill with 0xFF).

Two programmable opcode lists filter commands before they are decoded. A refuse list rejects opcodes, and an ignore list completes them with no effect. The block also runs a word-program mode with an automatically incremented address. While that mode is active, it shuts out every opcode except three. The status register can be read continuously on its own port, so the shifter can repeat it for every byte of a read-status transfer. Erase region sizes, the array size, the program size limit and the support for each erase kind and for the word-program mode are all parameters.

Top module: `spi_cmd_gate`

## Requirements
- R1: Each cycle with `txn_valid` high yields exactly one cycle of `res_valid` on the next clock. `res_code` is 0 for ok, 1 for error and 2 for invalid-opcode, and never 3. At most one store enable is high at a time, and only in a cycle that reports ok.
- R2: A transaction whose written-byte count is zero reports error and changes nothing.
- R3: An opcode that matches a live refuse-list entry reports invalid-opcode, and neither the status register nor the store is affected. The refuse list is checked before the ignore list.
- R4: An opcode that matches a live ignore-list entry, and no refuse entry, reports ok and has no effect, including no change to the write-enable latch.
- R5: Opcodes 0x06 and 0x50 set the write-enable latch (status bit 1). Every other executed command that does not end in error clears it. An erroring, refused, ignored or locked-out command leaves it unchanged.
- R6: Opcode 0x01 writes the status register only when bit 1 is set. In that case the status becomes byte 1 of the argument with bit 0 forced to 0, and bit 1 is then cleared. Status bit 0 (busy) always reads 0.
- R7: When word-program mode is supported and status bit 6 is set, any opcode other than 0xAD, 0x04 and 0x05 reports ok with `res_locked` high and has no effect.
- R8: Opcode 0xAD with bit 6 clear needs exactly 6 written bytes. It sets bit 6 and writes 2 bytes at the address, taken modulo the array size. Later 0xAD commands need exactly 3 written bytes and write 2 bytes at an internal address that advances by 2 and wraps. Any other length reports error.
- R9: Opcode 0x04 clears status bit 6 when word-program mode is supported.
- R10: Opcodes 0x20, 0x52 and 0xD8 need exactly 4 written bytes and 0 read bytes, or they report error. Each aligns the address down to its region size and emits an erase of that length. An erase kind that is disabled reports ok and does nothing.
- R11: Opcodes 0x60 and 0xC7 need exactly 1 written byte and 0 read bytes. Each emits an erase at address 0 whose length is the whole array.
- R12: Opcode 0x03 needs at least 4 written bytes and emits a read at the address modulo the array size. Opcode 0x02 needs at least 5 written bytes and at most `MAX_PROG` data bytes, and emits a program of (written count − 4) bytes at the wrapped address.
- R13: The two lists are loaded one entry at a time through `cfg_we`, `cfg_sel` (0 selects refuse, 1 selects ignore), `cfg_idx`, `cfg_op` and `cfg_live`. A write with `cfg_live` low disables the entry. All entries are disabled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_op | input | 8 | Opcode |
| txn_wcnt | input | CW | Bytes written, opcode included |
| txn_rcnt | input | CW | Bytes read |
| txn_arg | input | 40 | Bytes 1..5 after the opcode; byte 1 in [39:32], address = [39:16] |
| cfg_we | input | 1 | List entry write strobe |
| cfg_sel | input | 1 | 0 = refuse list, 1 = ignore list |
| cfg_idx | input | LIST_IW | Entry index |
| cfg_op | input | 8 | Opcode stored in the entry |
| cfg_live | input | 1 | Entry enabled |
| res_valid | output | 1 | Result present |
| res_code | output | 2 | 0 ok, 1 error, 2 invalid-opcode |
| res_locked | output | 1 | Opcode shut out by word-program mode |
| status_o | output | 8 | Status register |
| mem_wr_en | output | 1 | Program store bytes |
| mem_rd_en | output | 1 | Read from store |
| mem_erase_en | output | 1 | Fill region with 0xFF |
| mem_addr | output | AW | Store address |
| mem_len | output | AW+1 | Program or erase length in bytes |

## Verification
The bench builds the block with a 4 KiB array (`AW`=12), a program limit of 4 bytes (`MAX_PROG`=4), and the 0xD8 erase disabled (`BLKB_ON`=0). The small array puts address wrap within reach of ordinary addresses: 0x001FFF lands at 0xFFF, and the word-program address then rolls over to 0x001. The low program limit makes the over-length case cheap to reach, and the disabled erase exercises the ignore path for an unconfigured region. The 256- and 512-byte regions show alignment on unaligned inputs, and a chip erase covers the full 4096 bytes.

// File: rtl/spi_cmd_gate_pkg.sv
package spi_cmd_gate_pkg;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_SECT = 8'h20;
    localparam logic [7:0] OP_EWSR = 8'h50;
    localparam logic [7:0] OP_BLKA = 8'h52;
    localparam logic [7:0] OP_CHPA = 8'h60;
    localparam logic [7:0] OP_AAIW = 8'hAD;
    localparam logic [7:0] OP_CHPB = 8'hC7;
    localparam logic [7:0] OP_BLKB = 8'hD8;

    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_AAI  = 6;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_ERR   = 2'd1,
        RES_BADOP = 2'd2
    } res_e;

endpackage

// File: rtl/spi_cmd_gate_oplist.sv
module spi_cmd_gate_oplist #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_op,
    input  logic          wr_live,
    input  logic [7:0]    probe,
    output logic          hit
);

    logic [7:0] op_d [N];
    logic [7:0] op_q [N];
    logic [N-1:0] live_d, live_q;
    logic [N-1:0] match;

    always_comb begin
        live_d = live_q;
        for (int i = 0; i < N; i++) begin
            op_d[i] = op_q[i];
            if (wr_en && (32'(wr_idx) == i)) begin
                op_d[i]   = wr_op;
                live_d[i] = wr_live;
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    op_q[g]   <= 8'h00;
                    live_q[g] <= 1'b0;
                end else begin
                    op_q[g]   <= op_d[g];
                    live_q[g] <= live_d[g];
                end
            end
            assign match[g] = live_q[g] && (op_q[g] == probe);
        end
    endgenerate

    assign hit = |match;

endmodule

// File: rtl/spi_cmd_gate_erase.sv
module spi_cmd_gate_erase
    import spi_cmd_gate_pkg::*;
#(
    parameter int AW      = 12,
    parameter int SECT_LG = 8,
    parameter int BLKA_LG = 9,
    parameter int BLKB_LG = 10,
    parameter bit SECT_ON = 1'b1,
    parameter bit BLKA_ON = 1'b1,
    parameter bit BLKB_ON = 1'b1,
    parameter bit CHPA_ON = 1'b1,
    parameter bit CHPB_ON = 1'b1
) (
    input  logic [7:0]    op,
    input  logic [AW-1:0] addr,
    output logic          is_erase,
    output logic          live,
    output logic          whole,
    output logic [AW-1:0] base,
    output logic [AW:0]   len
);

    localparam logic [AW:0] SECT_LEN = (AW+1)'(1) << SECT_LG;
    localparam logic [AW:0] BLKA_LEN = (AW+1)'(1) << BLKA_LG;
    localparam logic [AW:0] BLKB_LEN = (AW+1)'(1) << BLKB_LG;
    localparam logic [AW:0] FULL_LEN = (AW+1)'(1) << AW;

    logic [AW:0] len_m1;

    always_comb begin
        is_erase = 1'b0;
        live     = 1'b0;
        whole    = 1'b0;
        len      = '0;
        case (op)
            OP_SECT: begin is_erase = 1'b1; live = SECT_ON; len = SECT_LEN; end
            OP_BLKA: begin is_erase = 1'b1; live = BLKA_ON; len = BLKA_LEN; end
            OP_BLKB: begin is_erase = 1'b1; live = BLKB_ON; len = BLKB_LEN; end
            OP_CHPA: begin is_erase = 1'b1; live = CHPA_ON; len = FULL_LEN; whole = 1'b1; end
            OP_CHPB: begin is_erase = 1'b1; live = CHPB_ON; len = FULL_LEN; whole = 1'b1; end
            default: ;
        endcase
        len_m1 = len - (AW+1)'(1);
        base   = addr & ~len_m1[AW-1:0];
    end

endmodule

// File: rtl/spi_cmd_gate.sv
module spi_cmd_gate
    import spi_cmd_gate_pkg::*;
#(
    parameter int AW       = 12,
    parameter int CW       = 10,
    parameter int LIST_N   = 8,
    parameter int MAX_PROG = 16,
    parameter int SECT_LG  = 8,
    parameter int BLKA_LG  = 9,
    parameter int BLKB_LG  = 10,
    parameter bit SECT_ON  = 1'b1,
    parameter bit BLKA_ON  = 1'b1,
    parameter bit BLKB_ON  = 1'b1,
    parameter bit CHPA_ON  = 1'b1,
    parameter bit CHPB_ON  = 1'b1,
    parameter bit AAI_ON   = 1'b1,
    parameter logic [7:0] INIT_STAT = 8'h00,
    localparam int LIST_IW = (LIST_N > 1) ? $clog2(LIST_N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_valid,
    input  logic [7:0]         txn_op,
    input  logic [CW-1:0]      txn_wcnt,
    input  logic [CW-1:0]      txn_rcnt,
    input  logic [39:0]        txn_arg,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [LIST_IW-1:0] cfg_idx,
    input  logic [7:0]         cfg_op,
    input  logic               cfg_live,
    output logic               res_valid,
    output logic [1:0]         res_code,
    output logic               res_locked,
    output logic [7:0]         status_o,
    output logic               mem_wr_en,
    output logic               mem_rd_en,
    output logic               mem_erase_en,
    output logic [AW-1:0]      mem_addr,
    output logic [AW:0]        mem_len
);

    typedef struct packed {
        logic [7:0]    stat;
        logic [AW-1:0] aai_ptr;
        logic          rv;
        res_e          code;
        logic          locked;
        logic          wr;
        logic          rd;
        logic          er;
        logic [AW-1:0] addr;
        logic [AW:0]   len;
    } st_t;

    localparam logic [7:0] BUSY_MASK = 8'h01 << SB_BUSY;

    st_t st_d, st_q;

    logic refuse_hit, ignore_hit;
    logic er_is, er_live, er_whole;
    logic [AW-1:0] er_base;
    logic [AW:0]   er_len;
    logic [AW-1:0] addr_w;
    logic [CW-1:0] prog_n;

    spi_cmd_gate_oplist #(.N(LIST_N)) u_refuse (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && !cfg_sel), .wr_idx(cfg_idx), .wr_op(cfg_op),
        .wr_live(cfg_live), .probe(txn_op), .hit(refuse_hit)
    );

    spi_cmd_gate_oplist #(.N(LIST_N)) u_ignore (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_sel), .wr_idx(cfg_idx), .wr_op(cfg_op),
        .wr_live(cfg_live), .probe(txn_op), .hit(ignore_hit)
    );

    assign addr_w = txn_arg[16 +: AW];
    assign prog_n = txn_wcnt - CW'(4);

    spi_cmd_gate_erase #(
        .AW(AW), .SECT_LG(SECT_LG), .BLKA_LG(BLKA_LG), .BLKB_LG(BLKB_LG),
        .SECT_ON(SECT_ON), .BLKA_ON(BLKA_ON), .BLKB_ON(BLKB_ON),
        .CHPA_ON(CHPA_ON), .CHPB_ON(CHPB_ON)
    ) u_erase (
        .op(txn_op), .addr(addr_w), .is_erase(er_is), .live(er_live),
        .whole(er_whole), .base(er_base), .len(er_len)
    );

    always_comb begin
        logic clr_wel;
        st_d        = st_q;
        st_d.rv     = 1'b0;
        st_d.code   = RES_OK;
        st_d.locked = 1'b0;
        st_d.wr     = 1'b0;
        st_d.rd     = 1'b0;
        st_d.er     = 1'b0;
        st_d.addr   = '0;
        st_d.len    = '0;
        clr_wel     = 1'b0;

        if (txn_valid) begin
            st_d.rv = 1'b1;
            if (txn_wcnt == '0) begin
                st_d.code = RES_ERR;
            end else if (refuse_hit) begin
                st_d.code = RES_BADOP;
            end else if (ignore_hit) begin
                st_d.code = RES_OK;
            end else if (AAI_ON && st_q.stat[SB_AAI] &&
                         !(txn_op inside {OP_AAIW, OP_WRDI, OP_RDSR})) begin
                st_d.locked = 1'b1;
            end else begin
                clr_wel = !(txn_op == OP_WREN || txn_op == OP_EWSR);
                if (er_is) begin
                    if (er_live) begin
                        if ((txn_wcnt != (er_whole ? CW'(1) : CW'(4))) || (txn_rcnt != '0)) begin
                            st_d.code = RES_ERR;
                        end else begin
                            st_d.er   = 1'b1;
                            st_d.addr = er_base;
                            st_d.len  = er_len;
                        end
                    end
                end else begin
                    case (txn_op)
                        OP_WREN, OP_EWSR: st_d.stat[SB_WEL] = 1'b1;
                        OP_WRSR: begin
                            if (st_q.stat[SB_WEL]) begin
                                st_d.stat = txn_arg[39:32] & ~BUSY_MASK;
                            end
                        end
                        OP_READ: begin
                            if (txn_wcnt < CW'(4)) begin
                                st_d.code = RES_ERR;
                            end else begin
                                st_d.rd   = 1'b1;
                                st_d.addr = addr_w;
                            end
                        end
                        OP_PROG: begin
                            if ((txn_wcnt < CW'(5)) || (prog_n > CW'(MAX_PROG))) begin
                                st_d.code = RES_ERR;
                            end else begin
                                st_d.wr   = 1'b1;
                                st_d.addr = addr_w;
                                st_d.len  = (AW+1)'(prog_n);
                            end
                        end
                        OP_AAIW: begin
                            if (AAI_ON) begin
                                if (!st_q.stat[SB_AAI]) begin
                                    if (txn_wcnt != CW'(6)) begin
                                        st_d.code = RES_ERR;
                                    end else begin
                                        st_d.stat[SB_AAI] = 1'b1;
                                        st_d.wr      = 1'b1;
                                        st_d.addr    = addr_w;
                                        st_d.len     = (AW+1)'(2);
                                        st_d.aai_ptr = addr_w + AW'(2);
                                    end
                                end else begin
                                    if (txn_wcnt != CW'(3)) begin
                                        st_d.code = RES_ERR;
                                    end else begin
                                        st_d.wr      = 1'b1;
                                        st_d.addr    = st_q.aai_ptr;
                                        st_d.len     = (AW+1)'(2);
                                        st_d.aai_ptr = st_q.aai_ptr + AW'(2);
                                    end
                                end
                            end
                        end
                        OP_WRDI: begin
                            if (AAI_ON) st_d.stat[SB_AAI] = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            if (clr_wel && (st_d.code != RES_ERR)) st_d.stat[SB_WEL] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stat    <= INIT_STAT & ~BUSY_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid    = st_q.rv;
    assign res_code     = st_q.code;
    assign res_locked   = st_q.locked;
    assign status_o     = st_q.stat;
    assign mem_wr_en    = st_q.wr;
    assign mem_rd_en    = st_q.rd;
    assign mem_erase_en = st_q.er;
    assign mem_addr     = st_q.addr;
    assign mem_len      = st_q.len;

endmodule

// File: rtl/spi_cmd_gate_chk.sv
module spi_cmd_gate_chk
    import spi_cmd_gate_pkg::*;
#(
    parameter int AW     = 12,
    parameter int CW     = 10,
    parameter bit AAI_ON = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txn_valid,
    input logic [CW-1:0] txn_wcnt,
    input logic          res_valid,
    input logic [1:0]    res_code,
    input logic          res_locked,
    input logic [7:0]    status_o,
    input logic          mem_wr_en,
    input logic          mem_rd_en,
    input logic          mem_erase_en,
    input logic [AW-1:0] mem_addr,
    input logic [AW:0]   mem_len
);

    logic [AW-1:0] len_m1;
    logic          any_mem;
    assign len_m1  = mem_len[AW-1:0] - AW'(1);
    assign any_mem = mem_wr_en || mem_rd_en || mem_erase_en;

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> res_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !res_valid);
    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_code != 2'd3);
    assert_mem_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_en, mem_rd_en, mem_erase_en}));
    assert_mem_needs_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_mem |-> (res_valid && res_code == RES_OK));
    assert_zero_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_wcnt == '0) |=> (res_code == RES_ERR));
    assert_refuse_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == RES_BADOP) |-> (!any_mem && $stable(status_o)));
    assert_busy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[SB_BUSY] == 1'b0);
    assert_lock_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_locked |-> (res_valid && res_code == RES_OK && !any_mem && $stable(status_o)));
    assert_aai_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (AAI_ON && mem_wr_en && status_o[SB_AAI]) |-> (mem_len == (AW+1)'(2)));
    assert_erase_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase_en |-> ((mem_addr & len_m1) == '0));

endmodule

bind spi_cmd_gate spi_cmd_gate_chk #(.AW(AW), .CW(CW), .AAI_ON(AAI_ON)) u_chk (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_wcnt(txn_wcnt),
    .res_valid(res_valid), .res_code(res_code), .res_locked(res_locked),
    .status_o(status_o), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_erase_en(mem_erase_en), .mem_addr(mem_addr), .mem_len(mem_len)
);

// File: tb/spi_cmd_gate_test.sv
module spi_cmd_gate_test;

    localparam int AW = 12;
    localparam int CW = 10;
    localparam int LIST_N = 8;
    localparam int LIST_IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 1'b0;
    logic [7:0] txn_op = '0;
    logic [CW-1:0] txn_wcnt = '0, txn_rcnt = '0;
    logic [39:0] txn_arg = '0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_live = 1'b0;
    logic [LIST_IW-1:0] cfg_idx = '0;
    logic [7:0] cfg_op = '0;
    logic res_valid, res_locked, mem_wr_en, mem_rd_en, mem_erase_en;
    logic [1:0] res_code;
    logic [7:0] status_o;
    logic [AW-1:0] mem_addr;
    logic [AW:0] mem_len;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_cmd_gate #(.AW(AW), .CW(CW), .LIST_N(LIST_N), .MAX_PROG(4), .BLKB_ON(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_op(txn_op),
        .txn_wcnt(txn_wcnt), .txn_rcnt(txn_rcnt), .txn_arg(txn_arg),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_op(cfg_op),
        .cfg_live(cfg_live), .res_valid(res_valid), .res_code(res_code),
        .res_locked(res_locked), .status_o(status_o), .mem_wr_en(mem_wr_en),
        .mem_rd_en(mem_rd_en), .mem_erase_en(mem_erase_en), .mem_addr(mem_addr),
        .mem_len(mem_len)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic [7:0] op, input int w, input int r, input logic [23:0] a,
                       input logic [7:0] b1 = 8'h00);
        @(negedge clk);
        txn_op = op; txn_wcnt = CW'(w); txn_rcnt = CW'(r);
        txn_arg = {a, 16'h0000};
        if (b1 != 8'h00) txn_arg[39:32] = b1;
        txn_valid = 1'b1;
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    task automatic cfg(input logic sel, input int idx, input logic [7:0] op, input logic live);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = LIST_IW'(idx); cfg_op = op; cfg_live = live;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 idle after reset", {31'b0, res_valid}, 0);
        chk("R6 reset status", {24'b0, status_o}, 32'h00);
        chk("R1 no store access at reset", {29'b0, mem_wr_en, mem_rd_en, mem_erase_en}, 0);
    endtask

    task automatic t_zero;
        txn(8'h06, 0, 0, 24'h0);
        chk("R1 result valid", {31'b0, res_valid}, 1);
        chk("R2 zero write error", {30'b0, res_code}, 1);
        chk("R2 zero write no WEL", {24'b0, status_o}, 32'h00);
    endtask

    task automatic t_wel;
        txn(8'h06, 1, 0, 24'h0);
        chk("R5 WREN sets WEL", {24'b0, status_o}, 32'h02);
        txn(8'h05, 1, 1, 24'h0);
        chk("R5 RDSR clears WEL", {24'b0, status_o}, 32'h00);
        txn(8'h50, 1, 0, 24'h0);
        chk("R5 EWSR sets WEL", {24'b0, status_o}, 32'h02);
    endtask

    task automatic t_wrsr;
        txn(8'h01, 2, 0, 24'h0, 8'h0F);
        chk("R6 WRSR busy masked, WEL cleared", {24'b0, status_o}, 32'h0C);
        txn(8'h01, 2, 0, 24'h0, 8'hF1);
        chk("R6 WRSR ignored without WEL", {24'b0, status_o}, 32'h0C);
        txn(8'h06, 1, 0, 24'h0);
        txn(8'h01, 2, 0, 24'h0);
        chk("R6 WRSR zero write", {24'b0, status_o}, 32'h00);
    endtask

    task automatic t_lists;
        cfg(1'b0, 0, 8'h06, 1'b1);
        cfg(1'b1, 0, 8'h06, 1'b1);
        cfg(1'b1, 1, 8'h05, 1'b1);
        txn(8'h06, 1, 0, 24'h0);
        chk("R3 refuse wins over ignore", {30'b0, res_code}, 2);
        chk("R3 refused has no effect", {24'b0, status_o}, 32'h00);
        txn(8'h50, 1, 0, 24'h0);
        txn(8'h05, 1, 1, 24'h0);
        chk("R4 ignored ok", {30'b0, res_code}, 0);
        chk("R4 ignored keeps WEL", {24'b0, status_o}, 32'h02);
        cfg(1'b0, 0, 8'h06, 1'b0);
        txn(8'h06, 1, 0, 24'h0);
        chk("R13 refuse entry disabled", {30'b0, res_code}, 0);
        cfg(1'b1, 1, 8'h05, 1'b0);
        txn(8'h05, 1, 1, 24'h0);
        chk("R13 ignore entry disabled", {24'b0, status_o}, 32'h00);
        cfg(1'b1, 0, 8'h06, 1'b0);
    endtask

    task automatic t_aai;
        txn(8'hAD, 5, 0, 24'h001FFF);
        chk("R8 short first word error", {30'b0, res_code}, 1);
        chk("R8 short first no mode", {24'b0, status_o}, 32'h00);
        txn(8'hAD, 6, 0, 24'h001FFF);
        chk("R8 first word write", {31'b0, mem_wr_en}, 1);
        chk("R8 first word wrapped addr", {20'b0, mem_addr}, 32'hFFF);
        chk("R8 first word len", {19'b0, mem_len}, 2);
        chk("R8 mode bit set", {24'b0, status_o}, 32'h40);
        txn(8'hAD, 3, 0, 24'h0);
        chk("R8 continuation addr wraps", {20'b0, mem_addr}, 32'h001);
        chk("R8 continuation write", {31'b0, mem_wr_en}, 1);
        txn(8'hAD, 4, 0, 24'h0);
        chk("R8 long continuation error", {30'b0, res_code}, 1);
        txn(8'h03, 4, 1, 24'h000100);
        chk("R7 locked flagged", {31'b0, res_locked}, 1);
        chk("R7 locked no read", {31'b0, mem_rd_en}, 0);
        chk("R7 locked ok code", {30'b0, res_code}, 0);
        txn(8'h05, 1, 1, 24'h0);
        chk("R7 RDSR passes in mode", {31'b0, res_locked}, 0);
        chk("R7 status during mode", {24'b0, status_o}, 32'h40);
        txn(8'h04, 1, 0, 24'h0);
        chk("R9 WRDI clears mode", {24'b0, status_o}, 32'h00);
    endtask

    task automatic t_erase;
        txn(8'h20, 4, 0, 24'h000345);
        chk("R10 sector erase strobe", {31'b0, mem_erase_en}, 1);
        chk("R10 sector aligned", {20'b0, mem_addr}, 32'h300);
        chk("R10 sector len", {19'b0, mem_len}, 256);
        txn(8'h52, 4, 0, 24'h0003FF);
        chk("R10 block aligned", {20'b0, mem_addr}, 32'h200);
        chk("R10 block len", {19'b0, mem_len}, 512);
        txn(8'hD8, 4, 0, 24'h000400);
        chk("R10 disabled erase ok", {30'b0, res_code}, 0);
        chk("R10 disabled erase idle", {31'b0, mem_erase_en}, 0);
        txn(8'h20, 4, 1, 24'h0);
        chk("R10 read count error", {30'b0, res_code}, 1);
        txn(8'h20, 5, 0, 24'h0);
        chk("R10 write count error", {30'b0, res_code}, 1);
        txn(8'h60, 1, 0, 24'h0);
        chk("R11 chip erase addr", {20'b0, mem_addr}, 0);
        chk("R11 chip erase len", {19'b0, mem_len}, 4096);
        txn(8'hC7, 2, 0, 24'h0);
        chk("R11 chip erase count error", {30'b0, res_code}, 1);
        txn(8'h06, 1, 0, 24'h0);
        txn(8'h20, 5, 0, 24'h0);
        chk("R5 error keeps WEL", {24'b0, status_o}, 32'h02);
        txn(8'hC7, 1, 0, 24'h0);
        chk("R11 C7 erase", {31'b0, mem_erase_en}, 1);
        chk("R5 erase clears WEL", {24'b0, status_o}, 32'h00);
    endtask

    task automatic t_rw;
        txn(8'h03, 4, 1, 24'h123456);
        chk("R12 read strobe", {31'b0, mem_rd_en}, 1);
        chk("R12 read wrapped addr", {20'b0, mem_addr}, 32'h456);
        txn(8'h03, 3, 1, 24'h0);
        chk("R12 short read error", {30'b0, res_code}, 1);
        txn(8'h02, 8, 0, 24'h000010);
        chk("R12 program strobe", {31'b0, mem_wr_en}, 1);
        chk("R12 program len", {19'b0, mem_len}, 4);
        chk("R12 program addr", {20'b0, mem_addr}, 32'h010);
        txn(8'h02, 9, 0, 24'h000010);
        chk("R12 program too long", {30'b0, res_code}, 1);
        txn(8'h02, 4, 0, 24'h000010);
        chk("R12 program too short", {30'b0, res_code}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_wel();
        t_wrsr();
        t_lists();
        t_aai();
        t_erase();
        t_rw();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule